// File: doc/BRIEF.md
# Address-Match Break Controller

This block snoops a processor bus and flags accesses that hit a programmed break address. Software loads a 24-bit break address and a control word through a small register port. The control word picks which bus master is watched, how many low address bits are ignored, which kind of access counts, and whether an interrupt request may be raised. Any qualifying access sets a sticky match flag. Software clears the flag by writing to the control word.

The request is not raised in the middle of an instruction. The block holds a match as pending until the core strobes `insn_end` to mark the end of an instruction. On the cycle after that strobe the request goes high, and it stays high as long as both the flag and the interrupt enable are set. Accesses driven by stack traffic or by fetching a branch target address are presented as ordinary data reads or writes, so they match like any other data access.

The bus side is a pure observer. It has a `bus_valid` qualifier and no ready signal. The block never stalls or back-pressures the bus, so a valid beat is always seen in the cycle it is offered.

Top module: `brk_watch`

## Requirements
- R1: After reset the break address reads 0, the control word reads 0, the flag is 0 and `brk_req` is 0.
- R2: With `reg_addr`=0 the port reads and writes the 24-bit break address. With `reg_addr`=1 it reads and writes the control word: bit 0 is the interrupt enable, bits 2:1 the condition, bits 5:3 the mask code and bit 6 the master select. The flag reads back in bit 7, and bits 23:8 read 0.
- R3: Master select 0 watches accesses with `bus_master`=0 (CPU). Master select 1 watches accesses with `bus_master`=1 (transfer controller). Accesses from the other master never match.
- R4: The condition field selects the access kind. 00 matches instruction fetches (`bus_fetch`=1). 01 matches data reads (`bus_fetch`=0, `bus_write`=0). 10 matches data writes (`bus_fetch`=0, `bus_write`=1). 11 matches any data access.
- R5: Mask code n (0 to 7) leaves address bits n-1 down to 0 out of the comparison. Code 0 compares all 24 bits.
- R6: A matching access sets the flag one cycle later. The flag stays set whatever the interrupt enable is.
- R7: Writing the control word with bit 7 at 0 clears the flag and drops any pending request. Writing bit 7 at 1 leaves the flag unchanged. If a match occurs in the same cycle as the clear, the match wins.
- R8: `brk_req` rises only in the cycle after an `insn_end` strobe, and only when that strobe comes with or after a match. It never rises before the strobe.
- R9: `brk_req` is high only while the flag and the interrupt enable are both 1. If the enable is set later while a released match is still flagged, the request goes high.
- R10: No match occurs while `bus_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | Register select: 0 break address, 1 control word |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational) |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_master | input | 1 | 0 CPU, 1 transfer controller |
| bus_fetch | input | 1 | 1 for instruction fetch |
| bus_write | input | 1 | 1 for data write, 0 for data read |
| bus_addr | input | 24 | Access address |
| insn_end | input | 1 | Strobe marking the end of an instruction |
| brk_req | output | 1 | Break interrupt request |

## Verification
Two cases are hardest to reach from the ports. The first is a match that lands in the same cycle as a software clear. The bench asserts the write strobe and a hitting bus beat on the same negative edge. It then checks that the flag survives, and that a later clear also removes the pending request. The second is a request unmasked late. The bench releases a match with the enable at 0, then sets the enable without touching the flag and checks that the request appears. All other matching behaviour is covered by a sweep over every control word against each master and access kind, with single address bits flipped around the mask boundary.

// File: rtl/brk_watch_pkg.sv
package brk_watch_pkg;
  localparam int unsigned CTL_W    = 7;
  localparam int unsigned FLAG_BIT = 7;
  localparam logic        SEL_ADDR = 1'b0;
  localparam logic        SEL_CTL  = 1'b1;

  typedef enum logic [1:0] {
    COND_FETCH = 2'b00,
    COND_RD    = 2'b01,
    COND_WR    = 2'b10,
    COND_RW    = 2'b11
  } cond_e;

  // field order follows control-word bit order 6..0
  typedef struct packed {
    logic       master_sel;
    logic [2:0] mask_code;
    cond_e      cond;
    logic       irq_en;
  } ctl_t;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_watch_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              flag,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] brk_addr,
  output ctl_t              ctl,
  output logic              flag_clr
);
  logic [ADDR_W-1:0] addr_q;
  ctl_t              ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      ctl_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == SEL_ADDR) addr_q <= reg_wdata;
      else                      ctl_q  <= ctl_t'(reg_wdata[CTL_W-1:0]);
    end
  end

  assign flag_clr = reg_wr && (reg_addr == SEL_CTL) && !reg_wdata[FLAG_BIT];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SEL_ADDR) begin
      reg_rdata = addr_q;
    end else begin
      reg_rdata[CTL_W-1:0] = ctl_q;
      reg_rdata[FLAG_BIT]  = flag;
    end
  end

  assign brk_addr = addr_q;
  assign ctl      = ctl_q;
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_watch_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              bus_valid,
  input  logic              bus_master,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] brk_addr,
  input  ctl_t              ctl,
  output logic              hit
);
  logic [ADDR_W-1:0] care;
  logic              addr_eq;
  logic              kind_ok;
  logic              master_ok;

  // bit i takes part in the compare when i >= mask code
  for (genvar i = 0; i < ADDR_W; i++) begin : g_care
    assign care[i] = ({29'd0, ctl.mask_code} <= 32'(i));
  end

  assign addr_eq   = ((bus_addr ^ brk_addr) & care) == '0;
  assign master_ok = (bus_master == ctl.master_sel);

  always_comb begin
    unique case (ctl.cond)
      COND_FETCH: kind_ok = bus_fetch;
      COND_RD:    kind_ok = !bus_fetch && !bus_write;
      COND_WR:    kind_ok = !bus_fetch && bus_write;
      default:    kind_ok = !bus_fetch;
    endcase
  end

  assign hit = bus_valid && master_ok && kind_ok && addr_eq;
endmodule

// File: rtl/brk_req.sv
module brk_req (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic flag_clr,
  input  logic insn_end,
  input  logic irq_en,
  output logic flag,
  output logic brk_req
);
  logic flag_q, pend_q, rel_q;
  logic flag_d, pend_d, rel_d;

  always_comb begin
    flag_d = hit | (flag_q & ~flag_clr);
    pend_d = (pend_q | hit) & ~insn_end & flag_d;
    rel_d  = (rel_q | (insn_end & (pend_q | hit))) & flag_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      pend_q <= pend_d;
      rel_q  <= rel_d;
    end
  end

  assign flag    = flag_q;
  assign brk_req = rel_q & flag_q & irq_en;
endmodule

// File: rtl/brk_watch.sv
module brk_watch
  import brk_watch_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_master,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              insn_end,
  output logic              brk_req
);
  logic [ADDR_W-1:0] brk_addr;
  ctl_t              ctl;
  logic              flag, flag_clr, hit, irq_en;

  assign irq_en = ctl.irq_en;

  brk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .flag(flag), .reg_rdata(reg_rdata),
    .brk_addr(brk_addr), .ctl(ctl), .flag_clr(flag_clr)
  );

  brk_match #(.ADDR_W(ADDR_W)) u_match (
    .bus_valid(bus_valid), .bus_master(bus_master), .bus_fetch(bus_fetch),
    .bus_write(bus_write), .bus_addr(bus_addr), .brk_addr(brk_addr),
    .ctl(ctl), .hit(hit)
  );

  brk_req u_req (
    .clk(clk), .rst_n(rst_n), .hit(hit), .flag_clr(flag_clr),
    .insn_end(insn_end), .irq_en(irq_en), .flag(flag), .brk_req(brk_req)
  );
endmodule

// File: rtl/brk_watch_chk.sv
module brk_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_valid,
  input logic insn_end,
  input logic hit,
  input logic flag,
  input logic flag_clr,
  input logic irq_en,
  input logic brk_req
);
  // R10
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !hit);
  // R6
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R7
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit) |=> !flag);
  // R9
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (flag && irq_en));
  // R8
  req_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(brk_req) && $past(irq_en)) |-> $past(insn_end));
endmodule

bind brk_watch brk_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .insn_end(insn_end),
  .hit(hit), .flag(flag), .flag_clr(flag_clr), .irq_en(irq_en),
  .brk_req(brk_req)
);

// File: tb/brk_watch_bench.sv
module brk_watch_bench;
  localparam int CLK_P = 10;
  localparam logic [23:0] BAR = 24'hA5C3B6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_addr = 1'b0, reg_wr = 1'b0;
  logic [23:0] reg_wdata = '0, reg_rdata;
  logic        bus_valid = 1'b0, bus_master = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        insn_end = 1'b0, brk_req;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  brk_watch u_brk_watch (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_master(bus_master), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .bus_addr(bus_addr), .insn_end(insn_end), .brk_req(brk_req)
  );

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [23:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [23:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic acc(input logic m, input logic f, input logic w, input logic [23:0] a);
    @(negedge clk); bus_valid = 1'b1; bus_master = m; bus_fetch = f; bus_write = w; bus_addr = a;
    @(negedge clk); bus_valid = 1'b0;
  endtask

  task automatic iend();
    @(negedge clk); insn_end = 1'b1;
    @(negedge clk); insn_end = 1'b0;
  endtask

  function automatic logic [23:0] cw(input logic ms, input logic [2:0] mk, input logic [1:0] cd, input logic ie, input logic f7);
    return {16'd0, f7, ms, mk, cd, ie};
  endfunction

  initial begin
    #(CLK_P * 190000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1'b0, v); chk(v == 24'h0, "R1", v, 24'h0);
    rd(1'b1, v); chk(v == 24'h0, "R1", v, 24'h0);
    chk(brk_req == 1'b0, "R1", {23'd0, brk_req}, 24'h0);
    // R2 readback; writing bit 7 as 1 does not set the flag (R7)
    wr(1'b0, BAR); rd(1'b0, v); chk(v == BAR, "R2", v, BAR);
    wr(1'b1, 24'hFFFFFF); rd(1'b1, v); chk(v == 24'h00007F, "R2", v, 24'h00007F);

    // sweep: every control word x master x access kind x address flip
    for (int c = 0; c < 128; c++) begin
      for (int k = 0; k < 6; k++) begin
        for (int fi = 0; fi < 8; fi++) begin
          automatic logic ie = c[0];
          automatic logic [1:0] cd = c[2:1];
          automatic logic [2:0] mk = c[5:3];
          automatic logic ms = c[6];
          automatic logic m = k[0];
          automatic logic f = (k[2:1] == 2'd0);
          automatic logic w = (k[2:1] == 2'd2);
          automatic int bit_n = (fi == 0) ? -1 : ((fi == 7) ? 11 : fi - 1);
          automatic logic [23:0] a = (bit_n < 0) ? BAR : (BAR ^ (24'd1 << bit_n));
          automatic logic kok = (cd == 2'd0) ? f : (cd == 2'd1) ? (!f && !w) : (cd == 2'd2) ? (!f && w) : !f;
          automatic logic aok = (bit_n < 0) || (bit_n < int'(mk));
          automatic logic exp_hit = (m == ms) && kok && aok;
          automatic string tag = (bit_n >= 0) ? "R5" : ((m != ms) ? "R3" : "R4");
          wr(1'b1, cw(ms, mk, cd, ie, 1'b0));
          acc(m, f, w, a);
          rd(1'b1, v);
          chk(v[7] == exp_hit, tag, {23'd0, v[7]}, {23'd0, exp_hit});
          chk(brk_req == 1'b0, "R8", {23'd0, brk_req}, 24'h0);
          iend();
          chk(brk_req == (exp_hit & ie), "R9", {23'd0, brk_req}, {23'd0, exp_hit & ie});
        end
      end
    end

    // R7 match in the same cycle as a clear: the match wins
    wr(1'b1, cw(1'b0, 3'd0, 2'd3, 1'b1, 1'b0));
    @(negedge clk);
    bus_valid = 1'b1; bus_master = 1'b0; bus_fetch = 1'b0; bus_write = 1'b1; bus_addr = BAR;
    reg_addr = 1'b1; reg_wdata = cw(1'b0, 3'd0, 2'd3, 1'b1, 1'b0); reg_wr = 1'b1;
    @(negedge clk); bus_valid = 1'b0; reg_wr = 1'b0;
    rd(1'b1, v); chk(v[7] == 1'b1, "R7", {23'd0, v[7]}, 24'h1);
    // R7 clear drops the pending request
    wr(1'b1, cw(1'b0, 3'd0, 2'd3, 1'b1, 1'b0));
    rd(1'b1, v); chk(v[7] == 1'b0, "R7", {23'd0, v[7]}, 24'h0);
    iend(); chk(brk_req == 1'b0, "R7", {23'd0, brk_req}, 24'h0);

    // R8 match coinciding with insn_end releases next cycle
    @(negedge clk);
    bus_valid = 1'b1; bus_fetch = 1'b0; bus_write = 1'b0; bus_addr = BAR; insn_end = 1'b1;
    @(negedge clk); bus_valid = 1'b0; insn_end = 1'b0;
    chk(brk_req == 1'b1, "R8", {23'd0, brk_req}, 24'h1);
    wr(1'b1, cw(1'b0, 3'd0, 2'd3, 1'b1, 1'b0));
    chk(brk_req == 1'b0, "R9", {23'd0, brk_req}, 24'h0);

    // R9 late enable raises a released request
    wr(1'b1, cw(1'b0, 3'd0, 2'd3, 1'b0, 1'b0));
    acc(1'b0, 1'b0, 1'b0, BAR); iend();
    chk(brk_req == 1'b0, "R9", {23'd0, brk_req}, 24'h0);
    wr(1'b1, cw(1'b0, 3'd0, 2'd3, 1'b1, 1'b1));
    chk(brk_req == 1'b1, "R9", {23'd0, brk_req}, 24'h1);
    wr(1'b1, cw(1'b0, 3'd0, 2'd3, 1'b1, 1'b0));
    chk(brk_req == 1'b0, "R9", {23'd0, brk_req}, 24'h0);

    // R10 idle bus never matches
    @(negedge clk); bus_valid = 1'b0; bus_addr = BAR; bus_fetch = 1'b0;
    @(negedge clk);
    rd(1'b1, v); chk(v[7] == 1'b0, "R10", {23'd0, v[7]}, 24'h0);
    iend(); chk(brk_req == 1'b0, "R10", {23'd0, brk_req}, 24'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule